// File: doc/BRIEF.md
# Link Integrity Test Monitor

This block decides whether the receive side of a twisted-pair link is alive. It watches two events that the front end has already qualified: a data-active flag that is high while a frame is arriving, and a one-cycle strobe for each received link test pulse. A shared millisecond tick drives the timers. If the line stays quiet for too long, the link is declared failed. While it is failed, the permits for transmit, receive and normal loopback are withdrawn. The link is restored at once by data activity, or by a counted run of link pulses that are spaced properly.

Pulses that arrive too close together are rejected. A run that breaks, either through a pulse that comes too early or through too long a silence, sends the monitor through a fail-extended state and back to a cleared count. On the transmit side the block requests an idle link pulse at a fixed interval while the transmitter is idle. A separate enable bypasses the whole check, and the link is then treated as good.

Top module: `lit_monitor`

## Requirements
- R1: After reset the link reads good (`link_good`=1, all permits 1, `led_link_n`=0), and `lp_req` is 0.
- R2: In the passing state, if LOSS_MS ticks pass with no data activity and no valid pulse, `link_good`, `tx_permit`, `rx_permit` and `lpbk_permit` all go to 0.
- R3: While failed, a pulse that arrives fewer than MIN_MS ticks after the last counted one leads through a fail-extended state to a cleared count, so a full run of CNT_MAX spaced pulses is needed again.
- R4: While failed, a cycle of `rx_active` restores `link_good` on the next clock edge.
- R5: While failed, CNT_MAX pulses spaced at least MIN_MS and less than MAX_MS apart restore the link. With CNT_MAX-1 such pulses it stays failed.
- R6: While failed, if MAX_MS ticks pass after a counted pulse with no further pulse, the count is cleared.
- R7: With `test_en` low, `link_good` is 1 whatever the line does. After re-enable, monitoring restarts in the passing state.
- R8: `lp_req` is a one-cycle pulse every LP_PERIOD_MS ticks. It is issued only while `test_en`=1, `force_lb`=0 and `tx_busy`=0.
- R9: `led_link_n` is 0 exactly while `link_good` is 1.
- R10: In the passing state, link pulses spaced at least MIN_MS and less than LOSS_MS apart keep the link good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe each millisecond |
| rx_active | input | 1 | Qualified received-data activity |
| lp_strobe | input | 1 | One-cycle strobe per received link pulse |
| test_en | input | 1 | Link test enable; low bypasses the check |
| tx_busy | input | 1 | Transmitter is sending a frame |
| force_lb | input | 1 | Forced internal loopback active |
| link_good | output | 1 | Link judged alive |
| tx_permit | output | 1 | Transmit allowed |
| rx_permit | output | 1 | Receive allowed |
| lpbk_permit | output | 1 | Normal loopback allowed |
| lp_req | output | 1 | Request to emit one idle link pulse |
| led_link_n | output | 1 | Link LED drive, active low |

## Verification
The assertions check four things on every cycle: the timer stays saturated, the pulse count is cleared in the fail-reset state, data activity leads to a pass on the next edge, and an early pulse leads into fail-extended. They also check that the bypass forces the passing state and that a pulse request is a single cycle raised only while enabled. The bench scenarios cover what needs a history of many milliseconds: loss after a quiet interval, recovery after exactly CNT_MAX spaced pulses but not after one fewer, the count restarting after an early pulse or a long gap, and the number of pulse requests over a window.

// File: rtl/lit_pkg.sv
// Shared types of the link integrity monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package lit_pkg;
    typedef enum logic [2:0] {
        LS_PASS   = 3'd0,
        LS_FRESET = 3'd1,
        LS_FWAIT  = 3'd2,
        LS_FAIL   = 3'd3,
        LS_FEXT   = 3'd4
    } link_state_e;
endpackage

// File: rtl/lit_ms_timer.sv
// Saturating millisecond counter that can be restarted.
// Assumes: tick is one clock wide; clear has priority over tick.
module lit_ms_timer #(
    parameter int unsigned LIMIT = 100,
    localparam int unsigned W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         done
);
    // Count ticks up to LIMIT, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (tick && count < W'(LIMIT))
            count <= count + W'(1);
    end

    assign done = (count >= W'(LIMIT));

    assert_timer_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= W'(LIMIT));
endmodule

// File: rtl/lit_link_fsm.sv
// Link state machine: pass, fail-reset, fail-wait, fail and fail-extended.
// Assumes: min_done and ivl_count come from timers restarted by this block's
// restart output; lp_strobe and rx_active are already qualified.
module lit_link_fsm
    import lit_pkg::*;
#(
    parameter int unsigned LOSS_MS = 100,
    parameter int unsigned MAX_MS  = 100,
    parameter int unsigned CNT_MAX = 2,
    parameter int unsigned IVL_W   = 7,
    localparam int unsigned CW     = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_en,
    input  logic             rx_active,
    input  logic             lp_strobe,
    input  logic             min_done,
    input  logic [IVL_W-1:0] ivl_count,
    output logic             restart,
    output logic             link_pass
);
    link_state_e st, nxt;
    logic [CW-1:0] cnt, cnt_nxt, cnt_inc;
    logic valid_lp, loss_hit, max_hit;

    assign valid_lp = lp_strobe && min_done;
    assign loss_hit = (ivl_count >= IVL_W'(LOSS_MS));
    assign max_hit  = (ivl_count >= IVL_W'(MAX_MS));
    assign cnt_inc  = cnt + CW'(1);

    // Next-state and pulse-count decision.
    always_comb begin
        nxt     = st;
        cnt_nxt = cnt;
        if (!test_en) begin
            nxt     = LS_PASS;
            cnt_nxt = '0;
        end else begin
            unique case (st)
                LS_PASS: begin
                    if (!rx_active && !valid_lp && loss_hit) begin
                        nxt     = LS_FRESET;
                        cnt_nxt = '0;
                    end
                end
                LS_FRESET: begin
                    cnt_nxt = '0;
                    nxt     = rx_active ? LS_PASS : LS_FWAIT;
                end
                LS_FWAIT: begin
                    if (rx_active) begin
                        nxt = LS_PASS;
                    end else if (lp_strobe) begin
                        cnt_nxt = cnt_inc;
                        nxt     = (cnt_inc >= CW'(CNT_MAX)) ? LS_PASS : LS_FAIL;
                    end
                end
                LS_FAIL: begin
                    if (rx_active) begin
                        nxt = LS_PASS;
                    end else if (lp_strobe && !min_done) begin
                        nxt = LS_FEXT;
                    end else if (lp_strobe) begin
                        cnt_nxt = cnt_inc;
                        if (cnt_inc >= CW'(CNT_MAX))
                            nxt = LS_PASS;
                    end else if (max_hit) begin
                        nxt = LS_FEXT;
                    end
                end
                LS_FEXT: begin
                    if (rx_active) begin
                        nxt = LS_PASS;
                    end else if (!lp_strobe) begin
                        nxt     = LS_FRESET;
                        cnt_nxt = '0;
                    end
                end
                default: nxt = LS_PASS;
            endcase
        end
    end

    // State and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= LS_PASS;
            cnt <= '0;
        end else begin
            st  <= nxt;
            cnt <= cnt_nxt;
        end
    end

    // Timers restart on any state change or on qualifying activity.
    always_comb begin
        restart = (nxt != st) || !test_en
               || (st == LS_PASS && (rx_active || valid_lp))
               || (st == LS_FAIL && valid_lp);
    end

    assign link_pass = (st == LS_PASS);

    assert_freset_cnt_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st == LS_FRESET |-> cnt == '0);
    assert_data_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && rx_active && st != LS_PASS) |=> st == LS_PASS);
    assert_early_pulse_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !rx_active && st == LS_FAIL && lp_strobe && !min_done) |=> st == LS_FEXT);
    assert_bypass_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> st == LS_PASS);
endmodule

// File: rtl/lit_idle_pulse_gen.sv
// Requests one idle link pulse every PERIOD_MS ticks while transmit is idle.
// Assumes: PERIOD_MS >= 2; the request is a single clock wide.
module lit_idle_pulse_gen #(
    parameter int unsigned PERIOD_MS = 10,
    localparam int unsigned PW = $clog2(PERIOD_MS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    output logic req
);
    logic [PW-1:0] pcnt;
    logic wrap;

    assign wrap = (pcnt == PW'(PERIOD_MS - 1));

    // Period counter and registered request.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            pcnt <= '0;
            req  <= 1'b0;
        end else begin
            req <= tick && wrap;
            if (tick)
                pcnt <= wrap ? '0 : pcnt + PW'(1);
        end
    end

    assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    assert_req_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(enable));
endmodule

// File: rtl/lit_monitor.sv
// Top of the link integrity monitor: timers, link state machine and the
// idle pulse requester, plus the gating outputs and LED drive.
// Assumes: all inputs synchronous to clk; ms_tick one cycle per millisecond.
module lit_monitor #(
    parameter int unsigned LOSS_MS      = 100,
    parameter int unsigned MIN_MS       = 4,
    parameter int unsigned MAX_MS       = 100,
    parameter int unsigned CNT_MAX      = 2,
    parameter int unsigned LP_PERIOD_MS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic rx_active,
    input  logic lp_strobe,
    input  logic test_en,
    input  logic tx_busy,
    input  logic force_lb,
    output logic link_good,
    output logic tx_permit,
    output logic rx_permit,
    output logic lpbk_permit,
    output logic lp_req,
    output logic led_link_n
);
    localparam int unsigned IVL_LIMIT = (LOSS_MS > MAX_MS) ? LOSS_MS : MAX_MS;
    localparam int unsigned IVL_W     = $clog2(IVL_LIMIT + 1);
    localparam int unsigned MIN_W     = $clog2(MIN_MS + 1);

    logic             restart, min_done, ivl_done, link_pass;
    logic [IVL_W-1:0] ivl_count;
    logic [MIN_W-1:0] min_count;

    lit_ms_timer #(.LIMIT(MIN_MS)) u_min_tmr (
        .clk(clk), .rst_n(rst_n), .clear(restart), .tick(ms_tick),
        .count(min_count), .done(min_done));

    lit_ms_timer #(.LIMIT(IVL_LIMIT)) u_ivl_tmr (
        .clk(clk), .rst_n(rst_n), .clear(restart), .tick(ms_tick),
        .count(ivl_count), .done(ivl_done));

    lit_link_fsm #(
        .LOSS_MS(LOSS_MS), .MAX_MS(MAX_MS), .CNT_MAX(CNT_MAX), .IVL_W(IVL_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .rx_active(rx_active),
        .lp_strobe(lp_strobe), .min_done(min_done), .ivl_count(ivl_count),
        .restart(restart), .link_pass(link_pass));

    lit_idle_pulse_gen #(.PERIOD_MS(LP_PERIOD_MS)) u_lpgen (
        .clk(clk), .rst_n(rst_n), .enable(test_en && !force_lb && !tx_busy),
        .tick(ms_tick), .req(lp_req));

    // Gate the data paths and drive the LED from the link verdict.
    always_comb begin
        link_good   = !test_en || link_pass;
        tx_permit   = link_good;
        rx_permit   = link_good;
        lpbk_permit = link_good;
        led_link_n  = !link_good;
    end

    assert_ivl_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_done |-> ivl_count == IVL_W'(IVL_LIMIT));
    assert_min_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        min_count <= MIN_W'(MIN_MS));
endmodule

// File: tb/sim_lit_monitor.sv
module sim_lit_monitor;
    localparam int LOSS = 20, MINI = 3, MAXI = 16, CNTM = 3, LPP = 10;
    localparam int TPM = 4;  // clocks per millisecond tick

    logic clk = 0, rst_n = 0, ms_tick = 0, rx_active = 0, lp_strobe = 0;
    logic test_en = 1, tx_busy = 0, force_lb = 0;
    logic link_good, tx_permit, rx_permit, lpbk_permit, lp_req, led_link_n;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    lit_monitor #(.LOSS_MS(LOSS), .MIN_MS(MINI), .MAX_MS(MAXI),
                  .CNT_MAX(CNTM), .LP_PERIOD_MS(LPP)) u0 (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .rx_active(rx_active),
        .lp_strobe(lp_strobe), .test_en(test_en), .tx_busy(tx_busy),
        .force_lb(force_lb), .link_good(link_good), .tx_permit(tx_permit),
        .rx_permit(rx_permit), .lpbk_permit(lpbk_permit), .lp_req(lp_req),
        .led_link_n(led_link_n));

    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            ms_tick = (k % TPM == 0);
            k++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_link(input string req, input bit exp);
        chk(link_good == exp, req, link_good, exp);
        chk(tx_permit == exp && rx_permit == exp && lpbk_permit == exp,
            {req, " permits"}, {tx_permit, rx_permit, lpbk_permit}, exp ? 7 : 0);
        chk(led_link_n == !exp, "R9 led", led_link_n, !exp);
    endtask

    task automatic wait_ms(input int n);
        repeat (n * TPM) @(negedge clk);
    endtask

    task automatic pulse();
        @(negedge clk); lp_strobe = 1;
        @(negedge clk); lp_strobe = 0;
    endtask

    task automatic data();
        @(negedge clk); rx_active = 1;
        @(negedge clk); rx_active = 0;
    endtask

    task automatic go_fail();
        data();
        wait_ms(LOSS + 8);
        chk_link("R2 setup fail", 0);
    endtask

    task automatic t_reset();
        chk_link("R1 reset", 1);
        chk(lp_req == 0, "R1 lp_req", lp_req, 0);
    endtask

    task automatic t_loss();
        data();
        wait_ms(LOSS - 4);
        chk_link("R2 before loss", 1);
        wait_ms(8);
        chk_link("R2 after loss", 0);
    endtask

    task automatic t_data_exit();
        go_fail();
        data();
        chk_link("R4 data exit", 1);
    endtask

    task automatic t_keepalive();
        data();
        for (int i = 0; i < 8; i++) begin
            wait_ms(8);
            pulse();
        end
        chk_link("R10 keepalive", 1);
    endtask

    task automatic t_pulse_recover();
        go_fail();
        for (int i = 0; i < CNTM - 1; i++) begin
            pulse();
            wait_ms(6);
        end
        chk_link("R5 one short", 0);
        pulse();
        chk_link("R5 recovered", 1);
    endtask

    task automatic t_early();
        go_fail();
        pulse();
        wait_ms(1);
        pulse();               // too soon
        wait_ms(6);
        for (int i = 0; i < CNTM - 1; i++) begin
            pulse();
            wait_ms(6);
        end
        chk_link("R3 count restarted", 0);
        pulse();
        chk_link("R3 full run", 1);
    endtask

    task automatic t_max();
        go_fail();
        pulse(); wait_ms(6); pulse();
        wait_ms(MAXI + 9);
        pulse(); wait_ms(6); pulse(); wait_ms(6);
        chk_link("R6 count cleared", 0);
        pulse();
        chk_link("R6 full run", 1);
    endtask

    task automatic t_bypass();
        go_fail();
        @(negedge clk); test_en = 0;
        @(negedge clk);
        chk_link("R7 bypass", 1);
        wait_ms(LOSS + 8);
        chk_link("R7 bypass hold", 1);
        @(negedge clk); test_en = 1;
        wait_ms(LOSS - 4);
        chk_link("R7 restart pass", 1);
    endtask

    task automatic count_req(input int ms, output int c);
        c = 0;
        repeat (ms * TPM) begin
            @(negedge clk);
            if (lp_req) c++;
        end
    endtask

    task automatic t_lp_gen();
        int c;
        count_req(100, c);
        chk(c >= 9 && c <= 11, "R8 period", c, 10);
        tx_busy = 1; count_req(50, c); tx_busy = 0;
        chk(c == 0, "R8 tx_busy", c, 0);
        force_lb = 1; count_req(50, c); force_lb = 0;
        chk(c == 0, "R8 force_lb", c, 0);
        test_en = 0; count_req(50, c); test_en = 1;
        chk(c == 0, "R8 test_en", c, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_loss();
        t_data_exit();
        t_keepalive();
        t_pulse_recover();
        t_early();
        t_max();
        t_bypass();
        t_lp_gen();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule